// File: doc/BRIEF.md
# Per-Channel Gating Output

This block drives one gating signal per transfer direction (receive and transmit) of a 24-channel, 193-bit time-division frame. Each direction keeps its own position counter, advanced by a bit-time enable and realigned by a frame sync. A 24-bit mask, written as three 8-bit words, states for each channel whether the gating signal stays high or low for the whole channel time. A serial controller downstream can AND its bit clock with the gating signal, so that it only sees the channels that carry its data. This is useful for fractional-rate links and primary-rate ISDN signalling channels.

The block runs in one clock domain. Each direction's bit-time enable marks the clock cycles that hold one bit time of that direction's stream. The output is a register that changes only when a new channel or the framing bit begins. A mask write therefore never cuts a channel short or stretches it.

Top module: `chan_gate_top`

## Requirements
- R1: While reset is asserted, and after it is released until the first channel is entered, both gate outputs are low, all mask bits are zero, and each direction's position is the framing bit.
- R2: A frame is 193 bit times: the framing bit, then 24 channels of 8 bits. The position advances once per clock in which that direction's bit_en is high, and after the last bit of channel 24 it returns to the framing bit with no frame sync.
- R3: The gate output of a direction is low for the whole framing-bit time.
- R4: Channel n (1 to 24) is controlled by bit (n-1) mod 8 of word (n-1) div 8. Word 0 holds channels 1 to 8, with channel 1 in bit 0. A mask bit of 1 holds the gate high for all 8 bit times of that channel.
- R5: A mask bit of 0 holds the gate low for all 8 bit times of that channel.
- R6: fsync sampled high together with bit_en moves that direction to the framing bit, from any position. fsync sampled while bit_en is low has no effect.
- R7: A write with wr_en high loads wr_data into the word chosen by wr_sel (0, 1 or 2) of the direction chosen by wr_dir (0 = receive, 1 = transmit). A write with wr_sel = 3 changes nothing.
- R8: The two directions have separate masks and separate position counters. A write or an enable for one direction never affects the other.
- R9: A mask write affects the gate only from the next channel start onward. The gate changes only at the first bit time of a channel or at the framing bit.
- R10: The gate is registered. It takes the new channel's level on the clock edge where bit_en is high and the position enters that channel, and it holds while bit_en is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_en | input | 2 | Per-direction bit-time enable (bit 0 receive, bit 1 transmit) |
| fsync | input | 2 | Per-direction frame sync, sampled with bit_en |
| wr_en | input | 1 | Mask write strobe |
| wr_dir | input | 1 | Write target direction, 0 receive, 1 transmit |
| wr_sel | input | 2 | Mask word select, 0 to 2 valid |
| wr_data | input | 8 | Mask word data |
| gate | output | 2 | Per-direction gating output (bit 0 receive, bit 1 transmit) |

## Verification
The hardest situation to reach is a mask change that lands inside a channel whose level it alters, because a glitch-free design and a broken one look the same at every channel start. The stimulus stops bit_en partway through channel 1, writes the word that controls that channel, and then resumes. It confirms that the gate keeps its old level to the end of the channel and takes the new level only in the next frame. A second directed case stops the enable mid-channel to show that the output holds. It then raises frame sync both with and without bit_en, in the middle of a frame, to separate a restart from a sync that must be ignored.

// File: rtl/chg_pkg.sv
package chg_pkg;
  localparam int CH_BITS = 8;
  localparam int NUM_CH  = 24;
  localparam int REG_W   = 8;
  localparam int NUM_REG = NUM_CH / REG_W;
  localparam int NUM_DIR = 2;
  localparam int CH_W    = $clog2(NUM_CH);
  localparam int BIT_W   = $clog2(CH_BITS);
  localparam int SEL_W   = $clog2(NUM_REG + 1);
  localparam int DIR_W   = $clog2(NUM_DIR);

  typedef struct packed {
    logic             frm;
    logic [CH_W-1:0]  ch;
    logic [BIT_W-1:0] bt;
  } slot_t;
endpackage

// File: rtl/chg_rst_sync.sv
module chg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/chg_slot_timer.sv
module chg_slot_timer
  import chg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  bit_en,
  input  logic  fsync,
  output slot_t cur,
  output slot_t nxt,
  output logic  adv
);
  slot_t cur_q;
  slot_t nxt_d;

  always_comb begin
    nxt_d = cur_q;
    if (fsync) begin
      nxt_d.frm = 1'b1;
      nxt_d.ch  = '0;
      nxt_d.bt  = '0;
    end else if (cur_q.frm) begin
      nxt_d.frm = 1'b0;
      nxt_d.ch  = '0;
      nxt_d.bt  = '0;
    end else if (cur_q.bt == BIT_W'(CH_BITS - 1)) begin
      nxt_d.bt = '0;
      if (cur_q.ch == CH_W'(NUM_CH - 1)) begin
        nxt_d.frm = 1'b1;
        nxt_d.ch  = '0;
      end else begin
        nxt_d.ch = cur_q.ch + 1'b1;
      end
    end else begin
      nxt_d.bt = cur_q.bt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q.frm <= 1'b1;
      cur_q.ch  <= '0;
      cur_q.bt  <= '0;
    end else if (bit_en) begin
      cur_q <= nxt_d;
    end
  end

  assign cur = cur_q;
  assign nxt = nxt_d;
  assign adv = bit_en;

  assert_chan_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cur_q.ch < CH_W'(NUM_CH));
  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !fsync && !cur_q.frm && cur_q.ch == CH_W'(NUM_CH - 1) &&
     cur_q.bt == BIT_W'(CH_BITS - 1)) |=> cur_q.frm);
  assert_sync_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && fsync) |=> (cur_q.frm && cur_q.ch == '0 && cur_q.bt == '0));
  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(cur_q));
endmodule

// File: rtl/chg_ctrl_regs.sv
module chg_ctrl_regs
  import chg_pkg::*;
#(
  parameter int DIR_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DIR_W-1:0]  wr_dir,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [REG_W-1:0]  wr_data,
  output logic [NUM_CH-1:0] mask
);
  logic dir_hit;
  assign dir_hit = wr_en && (wr_dir == DIR_W'(DIR_ID));

  for (genvar r = 0; r < NUM_REG; r++) begin : g_word
    logic             hit;
    logic [REG_W-1:0] word_q;
    logic [REG_W-1:0] word_d;

    assign hit = dir_hit && (wr_sel == SEL_W'(r));

    always_comb word_d = hit ? wr_data : word_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= word_d;
    end

    assign mask[r*REG_W +: REG_W] = word_q;
  end

  assert_bad_sel_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel >= SEL_W'(NUM_REG)) |=> $stable(mask));
  assert_other_dir_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_dir != DIR_W'(DIR_ID)) |=> $stable(mask));
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mask));
endmodule

// File: rtl/chg_gate_out.sv
module chg_gate_out
  import chg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  slot_t             nxt,
  input  slot_t             cur,
  input  logic [NUM_CH-1:0] mask,
  output logic              gate
);
  logic load;
  logic level;
  logic gate_q;
  logic gate_d;

  assign load  = adv && (nxt.frm || nxt.bt == '0);
  assign level = nxt.frm ? 1'b0 : mask[nxt.ch];

  always_comb gate_d = load ? level : gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate_d;
  end

  assign gate = gate_q;

  assert_frame_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cur.frm |-> !gate_q);
  assert_change_at_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gate_q) |-> (cur.frm || cur.bt == '0));
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(gate_q));
endmodule

// File: rtl/chan_gate_top.sv
module chan_gate_top
  import chg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_DIR-1:0] bit_en,
  input  logic [NUM_DIR-1:0] fsync,
  input  logic               wr_en,
  input  logic [DIR_W-1:0]   wr_dir,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [REG_W-1:0]   wr_data,
  output logic [NUM_DIR-1:0] gate
);
  logic rst_s_n;

  chg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    slot_t             cur;
    slot_t             nxt;
    logic              adv;
    logic [NUM_CH-1:0] mask;

    chg_slot_timer u_timer (
      .clk    (clk),
      .rst_n  (rst_s_n),
      .bit_en (bit_en[d]),
      .fsync  (fsync[d]),
      .cur    (cur),
      .nxt    (nxt),
      .adv    (adv)
    );

    chg_ctrl_regs #(.DIR_ID(d)) u_regs (
      .clk     (clk),
      .rst_n   (rst_s_n),
      .wr_en   (wr_en),
      .wr_dir  (wr_dir),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .mask    (mask)
    );

    chg_gate_out u_gate (
      .clk   (clk),
      .rst_n (rst_s_n),
      .adv   (adv),
      .nxt   (nxt),
      .cur   (cur),
      .mask  (mask),
      .gate  (gate[d])
    );
  end

  assert_low_in_reset_R1: assert property (@(posedge clk)
    !rst_s_n |-> (gate == '0));
endmodule

// File: tb/chan_gate_top_tb_top.sv
module chan_gate_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME_LEN  = 193;
  localparam int NVEC       = 6;
  localparam logic [23:0] RX_MASK [NVEC] = '{24'h000000, 24'hFFFFFF, 24'h555555,
                                             24'hAAAAAA, 24'h800001, 24'h0F00F0};
  localparam logic [23:0] TX_MASK [NVEC] = '{24'hFFFFFF, 24'h000000, 24'h00FF00,
                                             24'h123456, 24'hFFFFFE, 24'hA5A5A5};
  localparam int RX_HIGH [NVEC] = '{0, 192, 96, 96, 16, 64};
  localparam int TX_HIGH [NVEC] = '{192, 0, 64, 72, 184, 96};

  logic       clk;
  logic       rst_n;
  logic [1:0] bit_en;
  logic [1:0] fsync;
  logic       wr_en;
  logic       wr_dir;
  logic [1:0] wr_sel;
  logic [7:0] wr_data;
  logic [1:0] gate;

  int          checks;
  int          failures;
  string       req;
  logic [23:0] m [2];
  int          pos [2];
  logic        exp_g [2];
  int          hi_cnt [2];

  chan_gate_top dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_en  (bit_en),
    .fsync   (fsync),
    .wr_en   (wr_en),
    .wr_dir  (wr_dir),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .gate    (gate)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired during %s", req);
    report();
  end

  task automatic chk_gate(input int d);
    checks++;
    if (gate[d] !== exp_g[d]) begin
      failures++;
      $display("FAIL %s dir=%0d pos=%0d gate=%b expected=%b", req, d, pos[d], gate[d], exp_g[d]);
    end
  endtask

  task automatic chk_int(input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic tick(input logic [1:0] be, input logic [1:0] fs, input logic we,
                      input logic wd, input logic [1:0] ws, input logic [7:0] wdat);
    @(negedge clk);
    bit_en  = be;
    fsync   = fs;
    wr_en   = we;
    wr_dir  = wd;
    wr_sel  = ws;
    wr_data = wdat;
    @(posedge clk);
    #1;
    for (int d = 0; d < 2; d++) begin
      if (be[d]) begin
        pos[d] = fs[d] ? 0 : ((pos[d] == FRAME_LEN - 1) ? 0 : pos[d] + 1);
        if (pos[d] == 0)                exp_g[d] = 1'b0;
        else if ((pos[d] - 1) % 8 == 0) exp_g[d] = m[d][(pos[d] - 1) / 8];
        if (gate[d]) hi_cnt[d]++;
      end
    end
    if (we && ws < 2'd3) m[wd][ws*8 +: 8] = wdat;
    chk_gate(0);
    chk_gate(1);
  endtask

  task automatic wr(input logic d, input logic [1:0] s, input logic [7:0] v);
    tick(2'b00, 2'b00, 1'b1, d, s, v);
  endtask

  task automatic adv(input logic [1:0] be, input int n);
    for (int i = 0; i < n; i++) tick(be, 2'b00, 1'b0, 1'b0, 2'd0, 8'h00);
  endtask

  task automatic run_frame();
    hi_cnt[0] = 0;
    hi_cnt[1] = 0;
    tick(2'b11, 2'b11, 1'b0, 1'b0, 2'd0, 8'h00);
    adv(2'b11, FRAME_LEN - 1);
  endtask

  initial begin
    checks = 0; failures = 0; req = "R1";
    bit_en = '0; fsync = '0; wr_en = 1'b0; wr_dir = 1'b0; wr_sel = '0; wr_data = '0;
    m[0] = '0; m[1] = '0; pos[0] = 0; pos[1] = 0; exp_g[0] = 1'b0; exp_g[1] = 1'b0;
    hi_cnt[0] = 0; hi_cnt[1] = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk_gate(0);
    chk_gate(1);
    @(negedge clk);
    rst_n = 1'b1;
    adv(2'b00, 3);

    // R1: from reset the receive side sits on the framing bit, so channel 1 follows
    wr(1'b0, 2'd0, 8'h01);
    adv(2'b01, 10);

    // R2 R3 R4 R5 R8: table of masks per direction and expected high bit times
    for (int v = 0; v < NVEC; v++) begin
      req = "R4_R5_R8";
      for (int s = 0; s < 3; s++) begin
        wr(1'b0, 2'(s), RX_MASK[v][s*8 +: 8]);
        wr(1'b1, 2'(s), TX_MASK[v][s*8 +: 8]);
      end
      req = "R2_R3";
      run_frame();
      req = "R4_R5";
      chk_int("rx high count", hi_cnt[0], RX_HIGH[v]);
      chk_int("tx high count", hi_cnt[1], TX_HIGH[v]);
    end

    // R2: free-running wrap with no frame sync
    req = "R2";
    hi_cnt[0] = 0; hi_cnt[1] = 0;
    adv(2'b11, FRAME_LEN);
    chk_int("rx wrap high count", hi_cnt[0], 64);

    // R7: word select 3 is ignored
    req = "R7";
    wr(1'b0, 2'd3, 8'hFF);
    wr(1'b1, 2'd3, 8'h00);
    run_frame();
    chk_int("rx high after sel3", hi_cnt[0], 64);
    chk_int("tx high after sel3", hi_cnt[1], 96);

    // R9: write landing mid-channel waits for the next channel start
    req = "R9";
    wr(1'b0, 2'd0, 8'h00);
    wr(1'b0, 2'd1, 8'h00);
    wr(1'b0, 2'd2, 8'h00);
    tick(2'b01, 2'b01, 1'b0, 1'b0, 2'd0, 8'h00);
    adv(2'b01, 3);
    wr(1'b0, 2'd0, 8'h03);
    adv(2'b01, 5);
    chk_int("rx gate held low in channel 1", int'(gate[0]), 0);
    adv(2'b01, 1);
    chk_int("rx gate high at channel 2 start", int'(gate[0]), 1);
    adv(2'b01, FRAME_LEN - 10);
    tick(2'b01, 2'b01, 1'b0, 1'b0, 2'd0, 8'h00);
    adv(2'b01, 1);
    chk_int("rx channel 1 high next frame", int'(gate[0]), 1);

    // R10: stalled enable holds gate and position
    req = "R10";
    adv(2'b01, 3);
    adv(2'b00, 6);
    chk_int("rx gate held while stalled", int'(gate[0]), 1);
    adv(2'b01, 5);

    // R6: frame sync mid-frame, with and without the enable
    req = "R6";
    adv(2'b11, 40);
    tick(2'b00, 2'b11, 1'b0, 1'b0, 2'd0, 8'h00);
    tick(2'b11, 2'b11, 1'b0, 1'b0, 2'd0, 8'h00);
    chk_int("rx gate low after resync", int'(gate[0]), 0);
    adv(2'b11, 1);
    chk_int("rx channel 1 after resync", int'(gate[0]), 1);
    adv(2'b11, 20);

    report();
  end
endmodule